// File: doc/BRIEF.md
# Cookie-Kicked Watchdog Timer

This block is a 32-bit supervision timer for a memory-mapped motion-control design. Software programs a timeout value, and the block counts it down on a slow clock-enable tick. If software fails to service the timer in time, the block raises a sticky "expired" flag. It also emits a one-cycle pulse that tells the GPIO block to clear all of its direction and open-drain selections, so every pin falls back to being an input.

The block is serviced by writing a magic byte into the top eight bits of a separate key register. That write reloads the counter with the timeout value last written. Writing the timeout register itself also reloads the counter. Setting the most significant bit of the timeout value disables the timer. Three registers sit behind a 2-bit select: timeout (0), status (1) and key (2). Writes occur on cycles where `wr_en` is high. Reads are combinational on `rd_data`.

Top module: `cookie_watchdog`

## Requirements
- R1: The timeout register (select 0) stores all 32 written bits and returns them on `rd_data`. After reset it reads 0x8000_0000.
- R2: While bit 31 of the timeout register is 1, no number of ticks produces an expiry.
- R3: After the counter is loaded with N (bit 31 clear), ticks 1 to N produce no expiry, and tick N+1 produces one.
- R4: Expiry drives `gpio_clear` high for exactly one clock cycle, in the cycle after the expiring tick. The counter then stays stopped, and further ticks give no pulse until a reload.
- R5: After expiry, status bit 0 (select 1) reads 1 and `expired` is 1. Status bits 31:1 read 0.
- R6: A write to the key register (select 2) with 0x5A in bits 31:24 reloads the counter with the stored timeout value and restarts a stopped counter.
- R7: A key-register write with any other value in bits 31:24 leaves the counter untouched, including 0x5A placed in a different byte.
- R8: A write to the timeout register reloads the counter with the written value at once.
- R9: Writing a status word with bit 0 = 0 clears the expired flag. Writing bit 0 = 1 has no effect, and the flag otherwise holds.
- R10: When a reload and an expiring tick fall in the same cycle, the reload wins and no pulse is produced. When a status clear and an expiry fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Low-speed clock enable; one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 timeout, 1 status, 2 key |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `reg_sel` (key reads 0) |
| gpio_clear | output | 1 | One-cycle request to clear GPIO direction and open-drain bits |
| expired | output | 1 | Sticky expired flag (status bit 0) |

## Verification
Two functions can fall in the same clock: a service write and the tick that would take a zero counter to expiry. The bench provokes this by counting the counter down to zero and then driving the key write and the tick in one cycle. It judges the result by the absence of `gpio_clear` and by a full N+1 tick period following. A second collision drives a status clear in the same cycle as an expiring tick. Here the flag must read 1 afterwards, and the pulse must still appear.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    SEL_TMO  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_KEY  = 2'd2,
    SEL_NONE = 2'd3
  } wd_sel_e;

  // true when the service byte matches the magic key
  function automatic logic key_hit(input logic [7:0] top_byte, input logic [7:0] key);
    return top_byte == key;
  endfunction

  // one count step toward zero
  function automatic logic [31:0] count_step(input logic [31:0] c);
    return c - 32'd1;
  endfunction
endpackage

// File: rtl/wd_regs.sv
module wd_regs #(
  parameter int          DW      = 32,
  parameter logic [7:0]  KEY     = 8'h5A,
  parameter logic [DW-1:0] TMO_RST = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          expire_evt,
  output logic [DW-1:0] tmo_q,
  output logic          reload,
  output logic [DW-1:0] load_val,
  output logic          flag_q,
  output logic [DW-1:0] rd_data
);
  import wd_pkg::*;

  localparam int KW = 8;

  logic tmo_wr, key_wr, stat_clr;
  assign tmo_wr   = wr_en && (reg_sel == SEL_TMO);
  assign key_wr   = wr_en && (reg_sel == SEL_KEY) && key_hit(wr_data[DW-1 -: KW], KEY);
  assign stat_clr = wr_en && (reg_sel == SEL_STAT) && !wr_data[0];

  assign reload   = tmo_wr || key_wr;
  assign load_val = tmo_wr ? wr_data : tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q  <= TMO_RST;
      flag_q <= 1'b0;
    end else begin
      if (tmo_wr) tmo_q <= wr_data;
      if (expire_evt)    flag_q <= 1'b1;
      else if (stat_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_TMO:  rd_data = tmo_q;
      SEL_STAT: rd_data = {{(DW-1){1'b0}}, flag_q};
      default:  rd_data = '0;
    endcase
  end

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !expire_evt) |=> !flag_q);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> flag_q);
  // R1
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_wr |=> $stable(tmo_q));
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] CNT_RST = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          disable_i,
  input  logic          reload_i,
  input  logic [DW-1:0] load_val_i,
  output logic          expire_evt,
  output logic          bite_q
);
  import wd_pkg::*;

  logic [DW-1:0] cnt_q;
  logic          halted_q;
  logic          armed;
  logic          step_evt;

  assign armed      = !disable_i && !halted_q;
  assign expire_evt = tick_i && armed && (cnt_q == '0) && !reload_i;
  assign step_evt   = tick_i && armed && (cnt_q != '0) && !reload_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= CNT_RST;
      halted_q <= 1'b0;
      bite_q   <= 1'b0;
    end else begin
      bite_q <= expire_evt;
      if (reload_i) begin
        cnt_q    <= load_val_i;
        halted_q <= 1'b0;
      end else if (expire_evt) begin
        halted_q <= 1'b1;
      end else if (step_evt) begin
        cnt_q <= count_step(cnt_q);
      end
    end
  end

  // R4
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite_q |=> !bite_q);
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(load_val_i)) && !halted_q);
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> cnt_q == $past(cnt_q) - 1);
  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !reload_i) |=> $stable(cnt_q) && halted_q);
endmodule

// File: rtl/cookie_watchdog.sv
module cookie_watchdog #(
  parameter int            DW      = 32,
  parameter logic [7:0]    KEY     = 8'h5A,
  parameter logic [DW-1:0] TMO_RST = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          gpio_clear,
  output logic          expired
);
  logic [DW-1:0] tmo_q;
  logic [DW-1:0] load_val;
  logic          reload;
  logic          expire_evt;
  logic          wd_off;

  assign wd_off = tmo_q[DW-1];

  wd_regs #(.DW(DW), .KEY(KEY), .TMO_RST(TMO_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .expire_evt (expire_evt),
    .tmo_q      (tmo_q),
    .reload     (reload),
    .load_val   (load_val),
    .flag_q     (expired),
    .rd_data    (rd_data)
  );

  wd_countdown #(.DW(DW), .CNT_RST(TMO_RST)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .disable_i  (wd_off),
    .reload_i   (reload),
    .load_val_i (load_val),
    .expire_evt (expire_evt),
    .bite_q     (gpio_clear)
  );

  // R5
  flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_clear |-> expired);
  // R2
  off_no_bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_off && !reload) |=> !gpio_clear);
endmodule

// File: tb/tb_cookie_watchdog.sv
module tb_cookie_watchdog;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        gpio_clear, expired;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cookie_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .gpio_clear(gpio_clear), .expired(expired)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; #1; d = rd_data;
  endtask

  // one tick; returns pulse seen in the following cycle
  task automatic tick1(output logic p);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    p = gpio_clear;
  endtask

  task automatic ticks(input int n, output int pulses);
    logic p;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      tick1(p);
      if (p) pulses++;
    end
  endtask

  // N quiet ticks then one expiring tick with a single-cycle pulse
  task automatic expect_period(input string req, input int n);
    int pc; logic p;
    ticks(n, pc);
    check({req, " quiet ticks"}, pc, 0);
    tick1(p);
    check({req, " pulse at tick N+1"}, p, 1);
    @(negedge clk);
    check("R4 pulse one cycle", gpio_clear, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R5 reset flag", expired, 0);
    check("R4 reset pulse", gpio_clear, 0);
    rd(2'd0, d); check("R1 reset timeout", d, 32'h8000_0000);
  endtask

  task automatic t_disabled();
    int pc;
    ticks(40, pc); check("R2 default disabled", pc, 0);
    wr(2'd0, 32'h8000_0003);
    ticks(20, pc); check("R2 msb disables", pc, 0);
    check("R2 flag stays clear", expired, 0);
  endtask

  task automatic t_period();
    logic [31:0] d; int pc;
    wr(2'd0, 32'd5);
    rd(2'd0, d); check("R1 readback", d, 32'd5);
    expect_period("R3", 5);
    check("R5 flag set", expired, 1);
    rd(2'd1, d); check("R5 status word", d, 32'd1);
    ticks(10, pc); check("R4 stopped after expiry", pc, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    wr(2'd1, 32'd1);
    rd(2'd1, d); check("R9 write one no effect", d, 32'd1);
    wr(2'd1, 32'hFFFF_FFFE);
    rd(2'd1, d); check("R9 write zero clears", d, 32'd0);
    check("R9 expired output", expired, 0);
  endtask

  task automatic t_key();
    int pc;
    wr(2'd2, 32'h5A00_0000);
    expect_period("R6 restart after stop", 5);
    wr(2'd0, 32'd4);
    ticks(3, pc);
    wr(2'd2, 32'h5A00_0000);
    expect_period("R6 kick reload", 4);
    wr(2'd0, 32'd4);
    ticks(3, pc);
    wr(2'd2, 32'h5B00_0000);
    wr(2'd2, 32'h005A_0000);
    wr(2'd2, 32'h0000_005A);
    expect_period("R7 bad key ignored", 1);
  endtask

  task automatic t_tmo_reload();
    int pc;
    wr(2'd0, 32'd4);
    ticks(3, pc);
    wr(2'd0, 32'd2);
    expect_period("R8 timeout write reload", 2);
  endtask

  task automatic t_collide();
    int pc; logic p; logic [31:0] d;
    wr(2'd0, 32'd2);
    ticks(2, pc);
    tick = 1'b1; wr(2'd2, 32'h5A00_0000); tick = 1'b0;
    check("R10 kick beats expiry", gpio_clear, 0);
    expect_period("R10 full period after kick", 2);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd1);
    ticks(1, pc);
    tick = 1'b1; wr(2'd1, 32'd0); tick = 1'b0;
    p = gpio_clear;
    check("R10 pulse on clear collision", p, 1);
    rd(2'd1, d); check("R10 set beats clear", d, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_period();
    t_status();
    t_key();
    t_tmo_reload();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule